// File: doc/BRIEF.md
# Legacy IDE PIO Timing Controller

This block turns host programmed-I/O requests into read and write strobes for a legacy IDE channel that carries two drives. A single 16-bit configuration word, written and read back through a small register port, switches the channel on and off and moves it between the legacy primary and secondary address windows. The same bit picks which interrupt line carries the drive interrupt. The word also holds one fast timing bank, shared by both drives, and a 3-bit control nibble for each drive.

The host presents an address together with write data and a one-cycle read or write pulse. When the address falls inside the enabled channel's command or control window, the block runs a cycle in order: address setup, active strobe, an optional IORDY wait, then recovery. It ends with a one-cycle done pulse. A drive whose nibble selects the fast bank gets the programmed strobe and recovery lengths. Any other drive gets a fixed, slow mode-0 cycle. The drive is chosen by the last value written to the device/head register. The host issues a new request only after done.

Top module: `ide_pio_timer`

## Requirements
- R1: After reset the configuration word reads 0x0000, both strobes and both chip selects are high (inactive), `host_done` is low and both interrupt outputs are low.
- R2: All 16 configuration bits, including reserved bits 3, 7, 10 and 11, read back on `cfg_rdata` exactly as last written.
- R3: While bit 15 (channel enable) is 0, no request produces a strobe, a chip select or `host_done`, and both interrupt outputs stay low.
- R4: With bit 15 = 1 and bit 14 = 0, addresses 0x1F0–0x1F7 run a cycle with `ide_cs0_n` low and `ide_da` = address bits 2:0. Address 0x3F6 runs a cycle with `ide_cs1_n` low and `ide_da` = 6. `ide_intrq` is routed to `irq_pri` one clock later.
- R5: With bits 15 and 14 both set, addresses 0x170–0x177 and 0x376 are decoded in the same way, 0x1F0 is ignored, and `ide_intrq` is routed to `irq_sec`.
- R6: For a drive whose nibble bit 0 = 1, the strobe is low for 5 − F clocks, where F is bits 13:12. Recovery is 4 − G clocks, where G is bits 9:8. With one setup clock, `host_done` pulses for one clock, 2 + (5 − F) + (4 − G) clocks after the request edge.
- R7: For a drive whose nibble bit 0 = 0, the strobe is low for `M0_ACT_CLKS` clocks and `host_done` follows `M0_CYC_CLKS` + 1 clocks after the request, whatever bits 13:12 and 9:8 hold.
- R8: Drive 0's nibble is bits 2:0 and drive 1's is bits 6:4. Bit 4 of a write to command offset 6 selects the drive for every following cycle. The write itself still uses the previously selected drive.
- R9: When nibble bit 1 = 1 and `ide_iordy` is low at the end of the active period, the strobe stays low until the first clock edge at which `ide_iordy` is high.
- R10: A stuck-low `ide_iordy` extends the strobe by exactly `WDOG_CLKS` clocks, and the cycle then completes.
- R11: When nibble bit 1 = 0, `ide_iordy` has no effect on cycle length.
- R12: A write drives `host_wdata` on `ide_dd_out` with `ide_dd_oe` high and only `ide_diow_n` low. A read returns `ide_dd_in`, as captured at the end of the strobe, on `host_rdata` while `host_done` is high. The two strobes are never low together.
- R13: Nibble bit 2 (prefetch/posting) and reserved bits 3, 7, 10 and 11 do not change cycle timing. Bit 2 of the current drive's nibble appears on `ide_post_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration word read-back |
| host_addr | input | 16 | Host I/O address |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | One-cycle read request |
| host_wr | input | 1 | One-cycle write request |
| host_rdata | output | 16 | Read data, valid with done |
| host_done | output | 1 | One-cycle cycle-complete pulse |
| ide_cs0_n | output | 1 | Command-block chip select, active low |
| ide_cs1_n | output | 1 | Control-block chip select, active low |
| ide_da | output | 3 | Drive register address |
| ide_dior_n | output | 1 | Read strobe, active low |
| ide_diow_n | output | 1 | Write strobe, active low |
| ide_dd_out | output | 16 | Drive data out |
| ide_dd_oe | output | 1 | Drive data output enable |
| ide_dd_in | input | 16 | Drive data in |
| ide_iordy | input | 1 | Drive ready, low inserts wait states |
| ide_intrq | input | 1 | Drive interrupt request |
| irq_pri | output | 1 | Interrupt for the primary window |
| irq_sec | output | 1 | Interrupt for the secondary window |
| ide_post_en | output | 1 | Prefetch/posting enable of current drive |

## Verification
The bench sweeps all sixteen fast-bank field combinations and counts strobe-low clocks and done latency. An inverted field encoding, or an off-by-one count, shows up at once as a wrong strobe or recovery length. It changes drive selection part-way through a sequence, so that a design which applies the new drive to the selecting write itself, or which reads the wrong nibble, produces the other drive's timing. It holds IORDY low with and without sampling enabled, and releases it at a chosen clock. A missing watchdog would hang the cycle, and unconditional sampling would stretch cycles that should be fixed. It also sends requests to the window of the inactive channel and to a disabled channel, where any decode leak appears as a stray chip select or done.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACT,
    ST_WAIT,
    ST_REC
  } cyc_state_e;

  // per-drive control nibble (3 used bits of a 4-bit slot)
  typedef struct packed {
    logic post_en;
    logic iordy_en;
    logic fast;
  } drv_ctl_t;

  localparam int unsigned CFG_W        = 16;
  localparam int unsigned EN_BIT       = 15;
  localparam int unsigned SEC_BIT      = 14;
  localparam int unsigned ISP_LSB      = 12;
  localparam int unsigned RTC_LSB      = 8;
  localparam int unsigned NIB_STRIDE   = 4;
  localparam int unsigned DEVHEAD_OFS  = 6;
  localparam int unsigned DRVSEL_BIT   = 4;

endpackage

// File: rtl/ide_cfg_reg.sv
module ide_cfg_reg
  import ide_pio_pkg::*;
#(
  parameter int unsigned NUM_DRV = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [CFG_W-1:0]             wdata,
  input  logic                         intrq,
  output logic [CFG_W-1:0]             cfg_q,
  output logic                         chan_en,
  output logic                         chan_sec,
  output logic [1:0]                   isp_fld,
  output logic [1:0]                   rtc_fld,
  output drv_ctl_t [NUM_DRV-1:0]       drv_ctl,
  output logic                         irq_pri,
  output logic                         irq_sec
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q <= wdata;
    end
  end

  assign chan_en  = cfg_q[EN_BIT];
  assign chan_sec = cfg_q[SEC_BIT];
  assign isp_fld  = cfg_q[ISP_LSB +: 2];
  assign rtc_fld  = cfg_q[RTC_LSB +: 2];

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_nib
    assign drv_ctl[g].fast     = cfg_q[NIB_STRIDE*g + 0];
    assign drv_ctl[g].iordy_en = cfg_q[NIB_STRIDE*g + 1];
    assign drv_ctl[g].post_en  = cfg_q[NIB_STRIDE*g + 2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pri <= 1'b0;
      irq_sec <= 1'b0;
    end else begin
      irq_pri <= intrq && chan_en && !chan_sec;
      irq_sec <= intrq && chan_en && chan_sec;
    end
  end

  // R5
  irq_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_pri, irq_sec}));

  // R3
  irq_off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(chan_en) |-> !(irq_pri || irq_sec));

endmodule

// File: rtl/ide_addr_decode.sv
module ide_addr_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] PRI_CMD = 16'h01F0,
  parameter logic [ADDR_W-1:0] PRI_CTL = 16'h03F6,
  parameter logic [ADDR_W-1:0] SEC_CMD = 16'h0170,
  parameter logic [ADDR_W-1:0] SEC_CTL = 16'h0376
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              chan_en,
  input  logic              chan_sec,
  output logic              cmd_hit,
  output logic              ctl_hit,
  output logic [2:0]        da
);

  logic [ADDR_W-1:0] cmd_base;
  logic [ADDR_W-1:0] ctl_port;

  assign cmd_base = chan_sec ? SEC_CMD : PRI_CMD;
  assign ctl_port = chan_sec ? SEC_CTL : PRI_CTL;

  always_comb begin
    cmd_hit = chan_en && (addr[ADDR_W-1:3] == cmd_base[ADDR_W-1:3]);
    ctl_hit = chan_en && (addr == ctl_port);
    da      = addr[2:0];
  end

endmodule

// File: rtl/ide_timing_sel.sv
module ide_timing_sel
  import ide_pio_pkg::*;
#(
  parameter int unsigned NUM_DRV     = 2,
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned M0_ACT_CLKS = 17,
  parameter int unsigned M0_REC_CLKS = 42,
  localparam int unsigned DRV_W      = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  drv_ctl_t [NUM_DRV-1:0] drv_ctl,
  input  logic [DRV_W-1:0]       drv_idx,
  input  logic [1:0]             isp_fld,
  input  logic [1:0]             rtc_fld,
  output logic [CNT_W-1:0]       act_clks,
  output logic [CNT_W-1:0]       rec_clks,
  output logic                   iordy_en,
  output logic                   post_en
);

  localparam logic [CNT_W-1:0] M0_ACT = CNT_W'(M0_ACT_CLKS);
  localparam logic [CNT_W-1:0] M0_REC = CNT_W'(M0_REC_CLKS);

  logic [CNT_W-1:0] fast_act;
  logic [CNT_W-1:0] fast_rec;
  logic [CNT_W-1:0] drv_act [NUM_DRV];
  logic [CNT_W-1:0] drv_rec [NUM_DRV];

  // field 0 is the slowest setting of each range
  assign fast_act = CNT_W'(5) - CNT_W'(isp_fld);
  assign fast_rec = CNT_W'(4) - CNT_W'(rtc_fld);

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
    assign drv_act[g] = drv_ctl[g].fast ? fast_act : M0_ACT;
    assign drv_rec[g] = drv_ctl[g].fast ? fast_rec : M0_REC;
  end

  always_comb begin
    act_clks = drv_act[0];
    rec_clks = drv_rec[0];
    iordy_en = drv_ctl[0].iordy_en;
    post_en  = drv_ctl[0].post_en;
    for (int i = 1; i < NUM_DRV; i++) begin
      if (drv_idx == DRV_W'(i)) begin
        act_clks = drv_act[i];
        rec_clks = drv_rec[i];
        iordy_en = drv_ctl[i].iordy_en;
        post_en  = drv_ctl[i].post_en;
      end
    end
  end

endmodule

// File: rtl/ide_cycle_fsm.sv
module ide_cycle_fsm
  import ide_pio_pkg::*;
#(
  parameter int unsigned CNT_W      = 6,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SETUP_CLKS = 1,
  parameter int unsigned WDOG_CLKS  = 64,
  localparam int unsigned WD_W      = $clog2(WDOG_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_wr,
  input  logic              start_ctl,
  input  logic [2:0]        start_da,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic [CNT_W-1:0]  act_clks,
  input  logic [CNT_W-1:0]  rec_clks,
  input  logic              iordy_en,
  input  logic              iordy,
  input  logic [DATA_W-1:0] dd_in,
  output logic              busy,
  output logic              cs0_n,
  output logic              cs1_n,
  output logic [2:0]        da,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CLKS - 1);
  localparam logic [WD_W-1:0]  WD_LAST    = WD_W'(WDOG_CLKS - 1);

  cyc_state_e        state, nxt_state;
  logic [CNT_W-1:0]  cnt, nxt_cnt;
  logic [WD_W-1:0]   wcnt, nxt_wcnt;
  logic              capture;

  logic              wr_q, ctl_q, ien_q;
  logic [2:0]        da_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CNT_W-1:0]  act_q, rec_q;

  logic              launch;
  logic              wr_now, ctl_now;
  logic [2:0]        da_now;
  logic [DATA_W-1:0] wdata_now;
  logic              bus_on, strobe_on;

  assign launch    = (state == ST_IDLE) && start;
  assign wr_now    = launch ? start_wr    : wr_q;
  assign ctl_now   = launch ? start_ctl   : ctl_q;
  assign da_now    = launch ? start_da    : da_q;
  assign wdata_now = launch ? start_wdata : wdata_q;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    nxt_state = state;
    nxt_cnt   = cnt;
    nxt_wcnt  = wcnt;
    capture   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          nxt_state = ST_SETUP;
          nxt_cnt   = SETUP_LAST;
        end
      end
      ST_SETUP: begin
        if (cnt == '0) begin
          nxt_state = ST_ACT;
          nxt_cnt   = act_q - CNT_W'(1);
        end else begin
          nxt_cnt = cnt - CNT_W'(1);
        end
      end
      ST_ACT: begin
        if (cnt == '0) begin
          if (ien_q && !iordy) begin
            nxt_state = ST_WAIT;
            nxt_wcnt  = '0;
          end else begin
            nxt_state = ST_REC;
            nxt_cnt   = rec_q - CNT_W'(1);
            capture   = 1'b1;
          end
        end else begin
          nxt_cnt = cnt - CNT_W'(1);
        end
      end
      ST_WAIT: begin
        if (iordy || (wcnt == WD_LAST)) begin
          nxt_state = ST_REC;
          nxt_cnt   = rec_q - CNT_W'(1);
          capture   = 1'b1;
        end else begin
          nxt_wcnt = wcnt + WD_W'(1);
        end
      end
      ST_REC: begin
        if (cnt == '0) begin
          nxt_state = ST_IDLE;
        end else begin
          nxt_cnt = cnt - CNT_W'(1);
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  assign bus_on    = (nxt_state == ST_SETUP) || (nxt_state == ST_ACT) ||
                     (nxt_state == ST_WAIT);
  assign strobe_on = (nxt_state == ST_ACT) || (nxt_state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      wcnt    <= '0;
      wr_q    <= 1'b0;
      ctl_q   <= 1'b0;
      ien_q   <= 1'b0;
      da_q    <= '0;
      wdata_q <= '0;
      act_q   <= '0;
      rec_q   <= '0;
      cs0_n   <= 1'b1;
      cs1_n   <= 1'b1;
      da      <= '0;
      dior_n  <= 1'b1;
      diow_n  <= 1'b1;
      dd_out  <= '0;
      dd_oe   <= 1'b0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      state <= nxt_state;
      cnt   <= nxt_cnt;
      wcnt  <= nxt_wcnt;
      done  <= (state == ST_REC) && (nxt_state == ST_IDLE);
      if (launch) begin
        wr_q    <= start_wr;
        ctl_q   <= start_ctl;
        da_q    <= start_da;
        wdata_q <= start_wdata;
        act_q   <= act_clks;
        rec_q   <= rec_clks;
        ien_q   <= iordy_en;
      end
      if (capture && !wr_q) begin
        rdata <= dd_in;
      end
      cs0_n  <= !(bus_on && !ctl_now);
      cs1_n  <= !(bus_on && ctl_now);
      da     <= bus_on ? da_now : 3'd0;
      dior_n <= !(strobe_on && !wr_now);
      diow_n <= !(strobe_on && wr_now);
      dd_oe  <= bus_on && wr_now;
      if (bus_on && wr_now) begin
        dd_out <= wdata_now;
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!dior_n && !diow_n));

  // R4
  cs_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!dior_n || !diow_n) |-> (cs0_n != cs1_n));

  // R10
  wdog_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> (wcnt <= WD_LAST));

  // R9
  wait_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> ien_q);

  // R12
  write_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !diow_n |-> dd_oe);

endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import ide_pio_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned NUM_DRV     = 2,
  parameter int unsigned SETUP_CLKS  = 1,
  parameter int unsigned M0_ACT_CLKS = 17,
  parameter int unsigned M0_CYC_CLKS = 60,
  parameter int unsigned WDOG_CLKS   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic              host_wr,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic              ide_cs0_n,
  output logic              ide_cs1_n,
  output logic [2:0]        ide_da,
  output logic              ide_dior_n,
  output logic              ide_diow_n,
  output logic [DATA_W-1:0] ide_dd_out,
  output logic              ide_dd_oe,
  input  logic [DATA_W-1:0] ide_dd_in,
  input  logic              ide_iordy,
  input  logic              ide_intrq,
  output logic              irq_pri,
  output logic              irq_sec,
  output logic              ide_post_en
);

  localparam int unsigned M0_REC_CLKS = M0_CYC_CLKS - SETUP_CLKS - M0_ACT_CLKS;
  localparam int unsigned CNT_W = $clog2(M0_CYC_CLKS + 1);
  localparam int unsigned DRV_W = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1;

  logic                   chan_en, chan_sec;
  logic [1:0]             isp_fld, rtc_fld;
  drv_ctl_t [NUM_DRV-1:0] drv_ctl;
  logic                   cmd_hit, ctl_hit;
  logic [2:0]             dec_da;
  logic [CNT_W-1:0]       act_clks, rec_clks;
  logic                   iordy_en;
  logic                   busy, start;
  logic [DRV_W-1:0]       drv_sel;

  ide_cfg_reg #(.NUM_DRV(NUM_DRV)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .intrq(ide_intrq),
    .cfg_q(cfg_rdata), .chan_en(chan_en), .chan_sec(chan_sec),
    .isp_fld(isp_fld), .rtc_fld(rtc_fld), .drv_ctl(drv_ctl),
    .irq_pri(irq_pri), .irq_sec(irq_sec)
  );

  ide_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(host_addr), .chan_en(chan_en), .chan_sec(chan_sec),
    .cmd_hit(cmd_hit), .ctl_hit(ctl_hit), .da(dec_da)
  );

  ide_timing_sel #(
    .NUM_DRV(NUM_DRV), .CNT_W(CNT_W),
    .M0_ACT_CLKS(M0_ACT_CLKS), .M0_REC_CLKS(M0_REC_CLKS)
  ) u_tsel (
    .drv_ctl(drv_ctl), .drv_idx(drv_sel), .isp_fld(isp_fld), .rtc_fld(rtc_fld),
    .act_clks(act_clks), .rec_clks(rec_clks), .iordy_en(iordy_en),
    .post_en(ide_post_en)
  );

  assign start = (host_rd || host_wr) && (cmd_hit || ctl_hit) && !busy;

  // device/head write picks the drive for cycles after this one
  always_ff @(posedge clk) begin
    if (rst) begin
      drv_sel <= '0;
    end else if (start && host_wr && cmd_hit && (dec_da == 3'(DEVHEAD_OFS))) begin
      drv_sel <= DRV_W'(host_wdata[DRVSEL_BIT]);
    end
  end

  ide_cycle_fsm #(
    .CNT_W(CNT_W), .DATA_W(DATA_W),
    .SETUP_CLKS(SETUP_CLKS), .WDOG_CLKS(WDOG_CLKS)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .start_wr(host_wr),
    .start_ctl(ctl_hit), .start_da(dec_da), .start_wdata(host_wdata),
    .act_clks(act_clks), .rec_clks(rec_clks), .iordy_en(iordy_en),
    .iordy(ide_iordy), .dd_in(ide_dd_in), .busy(busy),
    .cs0_n(ide_cs0_n), .cs1_n(ide_cs1_n), .da(ide_da),
    .dior_n(ide_dior_n), .diow_n(ide_diow_n), .dd_out(ide_dd_out),
    .dd_oe(ide_dd_oe), .rdata(host_rdata), .done(host_done)
  );

  // R3
  no_cycle_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !chan_en) |=> (ide_cs0_n && ide_cs1_n));

endmodule

// File: tb/ide_pio_timer_tb.sv
module ide_pio_timer_tb_top;

  localparam int M0_ACT = 17;
  localparam int M0_CYC = 60;
  localparam int WDOG   = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [15:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_rdata;
  logic        host_done;
  logic        ide_cs0_n, ide_cs1_n, ide_dior_n, ide_diow_n, ide_dd_oe;
  logic [2:0]  ide_da;
  logic [15:0] ide_dd_out;
  logic [15:0] ide_dd_in = 16'h5A3C;
  logic        ide_iordy = 1'b1;
  logic        ide_intrq = 1'b0;
  logic        irq_pri, irq_sec, ide_post_en;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ide_pio_timer #(.M0_ACT_CLKS(M0_ACT), .M0_CYC_CLKS(M0_CYC), .WDOG_CLKS(WDOG)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rd(host_rd), .host_wr(host_wr),
    .host_rdata(host_rdata), .host_done(host_done), .ide_cs0_n(ide_cs0_n),
    .ide_cs1_n(ide_cs1_n), .ide_da(ide_da), .ide_dior_n(ide_dior_n),
    .ide_diow_n(ide_diow_n), .ide_dd_out(ide_dd_out), .ide_dd_oe(ide_dd_oe),
    .ide_dd_in(ide_dd_in), .ide_iordy(ide_iordy), .ide_intrq(ide_intrq),
    .irq_pri(irq_pri), .irq_sec(irq_sec), .ide_post_en(ide_post_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // runs one cycle; rel_at > 0 raises IORDY once that many strobe-low clocks are seen
  task automatic do_io(input logic [15:0] a, input bit wr, input logic [15:0] wd,
                       input int exp_lo, input int exp_total, input int rel_at,
                       input bit exp_ctl, input string req);
    int n = 0; int lo = 0; bit seen = 0; bit got = 0;
    logic c0 = 1, c1 = 1, rstb = 1, wstb = 1, oe = 0; logic [2:0] d = 0; logic [15:0] o = 0;
    @(negedge clk);
    host_addr = a; host_wdata = wd; host_wr = wr; host_rd = !wr;
    @(negedge clk);
    host_wr = 0; host_rd = 0;
    n = 1;
    while (n < 1000) begin
      if (!ide_dior_n || !ide_diow_n) begin
        if (!seen) begin
          seen = 1; c0 = ide_cs0_n; c1 = ide_cs1_n; d = ide_da;
          rstb = ide_dior_n; wstb = ide_diow_n; oe = ide_dd_oe; o = ide_dd_out;
        end
        lo++;
        if (rel_at > 0 && lo == rel_at) ide_iordy = 1'b1;
      end
      if (host_done) begin got = 1; break; end
      n++;
      @(negedge clk);
    end
    chk(lo == exp_lo, {req, " strobe width"}, lo, exp_lo);
    chk(got && n == exp_total, {req, " done latency"}, n, exp_total);
    chk(seen && (exp_ctl ? (c1 == 0 && c0 == 1 && d == 3'd6)
                         : (c0 == 0 && c1 == 1 && d == a[2:0])),
        {req, " chip select/da"}, {c0, c1, d}, exp_ctl ? 32'b10110 : {2'b01, a[2:0]});
    if (wr) begin
      chk(wstb == 0 && rstb == 1 && oe == 1 && o == wd, "R12 write data", o, wd);
    end else begin
      chk(rstb == 0 && wstb == 1 && host_rdata == ide_dd_in, "R12 read data",
          host_rdata, ide_dd_in);
    end
    ide_iordy = 1'b1;
  endtask

  task automatic no_io(input logic [15:0] a, input string req);
    bit bad = 0;
    @(negedge clk);
    host_addr = a; host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    for (int i = 0; i < M0_CYC + 8; i++) begin
      if (!ide_cs0_n || !ide_cs1_n || !ide_dior_n || !ide_diow_n || host_done) bad = 1;
      @(negedge clk);
    end
    chk(!bad, {req, " ignored address"}, bad, 0);
  endtask

  function automatic int fast_total(input int f, input int g, input int w);
    return 1 + (5 - f) + w + (4 - g) + 1;
  endfunction

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(cfg_rdata == 16'h0000, "R1 cfg reset", cfg_rdata, 0);
    chk(ide_dior_n && ide_diow_n && ide_cs0_n && ide_cs1_n && !host_done &&
        !irq_pri && !irq_sec, "R1 outputs idle", 0, 0);

    // R2: read-back sweep
    k = 0;
    for (int b = 0; b < 16; b++) begin
      cfg_write(16'(1 << b) ^ 16'h0C88);
      if (cfg_rdata != (16'(1 << b) ^ 16'h0C88)) k++;
    end
    chk(k == 0, "R2 readback sweep", k, 0);

    // R3: disabled channel
    cfg_write(16'h3FFF);
    no_io(16'h01F0, "R3");
    no_io(16'h03F6, "R3");
    ide_intrq = 1; @(negedge clk); @(negedge clk);
    chk(!irq_pri && !irq_sec, "R3 irq masked", {irq_pri, irq_sec}, 0);
    ide_intrq = 0;

    // R4: primary window, mode-0 drive
    cfg_write(16'h8000);
    for (int o = 0; o < 8; o++)
      do_io(16'h01F0 + 16'(o), 0, 0, M0_ACT, M0_CYC + 1, 0, 0, "R4 primary cmd");
    do_io(16'h03F6, 0, 0, M0_ACT, M0_CYC + 1, 0, 1, "R4 primary ctl");
    no_io(16'h0170, "R4");
    ide_intrq = 1; @(negedge clk); @(negedge clk);
    chk(irq_pri && !irq_sec, "R4 irq route", {irq_pri, irq_sec}, 2);
    ide_intrq = 0;

    // R5: secondary window
    cfg_write(16'hC000);
    for (int o = 0; o < 8; o++)
      do_io(16'h0170 + 16'(o), 0, 0, M0_ACT, M0_CYC + 1, 0, 0, "R5 secondary cmd");
    do_io(16'h0376, 0, 0, M0_ACT, M0_CYC + 1, 0, 1, "R5 secondary ctl");
    no_io(16'h01F0, "R5");
    no_io(16'h03F6, "R5");
    ide_intrq = 1; @(negedge clk); @(negedge clk);
    chk(!irq_pri && irq_sec, "R5 irq route", {irq_pri, irq_sec}, 1);
    ide_intrq = 0;

    // R6: fast bank sweep on drive 0
    for (int f = 0; f < 4; f++)
      for (int g = 0; g < 4; g++) begin
        cfg_write(16'h8001 | 16'(f << 12) | 16'(g << 8));
        do_io(16'h01F1, 0, 0, 5 - f, fast_total(f, g, 0), 0, 0, "R6 fast bank");
      end

    // R7: mode-0 regardless of fields
    cfg_write(16'hB300);
    do_io(16'h01F2, 0, 0, M0_ACT, M0_CYC + 1, 0, 0, "R7 mode0 fields max");
    cfg_write(16'h9200);
    do_io(16'h01F2, 1, 16'h1234, M0_ACT, M0_CYC + 1, 0, 0, "R7 mode0 write");

    // R8: drive selection, drive 0 fast, drive 1 mode-0
    cfg_write(16'hB301);
    do_io(16'h01F6, 1, 16'h00F0, 2, fast_total(3, 3, 0), 0, 0, "R8 select write old drive");
    do_io(16'h01F0, 0, 0, M0_ACT, M0_CYC + 1, 0, 0, "R8 drive1 mode0");
    do_io(16'h01F6, 1, 16'h00E0, M0_ACT, M0_CYC + 1, 0, 0, "R8 deselect write old drive");
    do_io(16'h01F0, 0, 0, 2, fast_total(3, 3, 0), 0, 0, "R8 drive0 fast");
    cfg_write(16'hA110);
    do_io(16'h01F7, 0, 0, M0_ACT, M0_CYC + 1, 0, 0, "R8 drive0 slow nibble");
    do_io(16'h01F6, 1, 16'h0010, M0_ACT, M0_CYC + 1, 0, 0, "R8 select drive1");
    do_io(16'h01F7, 0, 0, 3, fast_total(2, 1, 0), 0, 0, "R8 drive1 fast nibble");
    do_io(16'h01F6, 1, 16'h0000, 3, fast_total(2, 1, 0), 0, 0, "R8 back to drive0");

    // R9 / R10 / R11: IORDY on drive 0, fields F=1 G=2
    cfg_write(16'h9203);
    ide_iordy = 0;
    do_io(16'h01F0, 0, 0, 4 + 3, fast_total(1, 2, 3), 4 + 3, 0, "R9 iordy release");
    ide_iordy = 0;
    do_io(16'h01F0, 1, 16'hBEEF, 4 + 9, fast_total(1, 2, 9), 4 + 9, 0, "R9 iordy write");
    ide_iordy = 0;
    do_io(16'h01F0, 0, 0, 4 + WDOG, fast_total(1, 2, WDOG), 0, 0, "R10 watchdog");
    cfg_write(16'h9201);
    ide_iordy = 0;
    do_io(16'h01F0, 0, 0, 4, fast_total(1, 2, 0), 0, 0, "R11 iordy ignored");
    cfg_write(16'h8002);
    ide_iordy = 0;
    do_io(16'h01F0, 0, 0, M0_ACT + 5, M0_CYC + 1 + 5, M0_ACT + 5, 0, "R9 mode0 iordy");

    // R12: data paths with distinct patterns
    cfg_write(16'h8001);
    ide_dd_in = 16'hC3A5;
    do_io(16'h01F0, 0, 0, 5, fast_total(0, 0, 0), 0, 0, "R12 read");
    do_io(16'h01F0, 1, 16'hA5C3, 5, fast_total(0, 0, 0), 0, 0, "R12 write");

    // R13: prefetch and reserved bits leave timing alone
    cfg_write(16'h9E8D);
    @(negedge clk);
    chk(ide_post_en == 1, "R13 post enable", ide_post_en, 1);
    do_io(16'h01F3, 0, 0, 4, fast_total(1, 2, 0), 0, 0, "R13 reserved bits");
    cfg_write(16'h8004);
    do_io(16'h01F3, 0, 0, M0_ACT, M0_CYC + 1, 0, 0, "R13 prefetch only");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule